// File: doc/BRIEF.md
# Bus wait-state stretcher

This block sits beside a processor's memory interface and decides when a memory cycle must be lengthened by one extra clock. It counts accesses, one for each cycle in which the access strobe is high. When the count reaches the active ratio, it raises a single-cycle stretch request toward the processor and starts counting again from zero.

The ratio is not fixed. It is chosen at run time from the state of the address-translation features. The base ratio is three accesses per extra clock. It drops to two when the fast-translation flag is set, or when both page translation and the address window are enabled. In the slow clock mode no stretching happens at all and the counter is held at zero.

Either ratio may be set to zero through a parameter. A zero ratio turns stretching off while that ratio is selected.

Top module: `wst_stretcher`

## Requirements
- R1: A synchronous active-high reset clears the access count and holds the stretch request low. After reset, a full ratio of strobes is needed before the first request, and a strobe seen during reset does not count.
- R2: While the clock-mode input is low (slow), no request is raised and the count is cleared. On return to fast mode, a full ratio of strobes is needed again.
- R3: With the fast-translation flag low, and with translation and the window not both enabled, the ratio is 3 (parameter, default 3): one request for every third strobe.
- R4: With the fast-translation flag high, the ratio is 2 (parameter, default 2).
- R5: With page translation and the address window both enabled, the ratio is 2. The window flag alone, or translation alone, leaves the ratio at 3.
- R6: The request goes high in the cycle after the clock edge that registers the completing strobe. It stays high for exactly one cycle, and the count restarts from zero at that same edge.
- R7: A cycle with the strobe low neither advances the count nor raises a request. The count is kept across such cycles.
- R8: When the selected ratio is zero, no request is raised and the count is held at zero.
- R9: If the ratio is lowered while the count already equals or exceeds the new ratio minus one, the next strobe raises the request, because the count has reached or passed the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | High for one cycle per memory access |
| fast_clk | input | 1 | Clock mode: 1 fast (stretching active), 0 slow |
| xlat_en | input | 1 | Page translation enabled |
| xlat_quick | input | 1 | Fast-translation flag |
| win_en | input | 1 | Address window enabled |
| stretch | output | 1 | One-cycle extra-clock request to the processor |

## Verification
Two functions can land on the same edge: the strobe that completes a count, and the clock mode dropping to slow (or reset being applied). The bench builds the count to one short of the ratio, then drives the completing strobe in the same cycle that the fast flag falls, and then again in a cycle with reset high. A scoreboard model expects no request in either case. It also expects that a full ratio of strobes is needed after fast mode returns, so a count that survived the collision shows up as an early request. A ratio cut from 3 to 2 in the middle of a count is provoked the same way, and the request is expected on the very next strobe.

// File: rtl/wst_pkg.sv
package wst_pkg;

    typedef enum logic {
        RATE_BASE  = 1'b0,
        RATE_QUICK = 1'b1
    } rate_e;

    // Pick the ratio class from the translation flags
    function automatic rate_e pick_rate(input logic xlat_en,
                                        input logic xlat_quick,
                                        input logic win_en);
        if (xlat_quick || (xlat_en && win_en))
            return RATE_QUICK;
        return RATE_BASE;
    endfunction

endpackage

// File: rtl/wst_ratio_sel.sv
module wst_ratio_sel #(
    parameter int RATIO_BASE  = 3,
    parameter int RATIO_QUICK = 2,
    parameter int RW          = 3
) (
    input  logic          xlat_en,
    input  logic          xlat_quick,
    input  logic          win_en,
    output logic [RW-1:0] ratio
);
    import wst_pkg::*;

    localparam logic [RW-1:0] BASE_V  = RW'(RATIO_BASE);
    localparam logic [RW-1:0] QUICK_V = RW'(RATIO_QUICK);

    rate_e sel;

    always_comb begin
        sel   = pick_rate(xlat_en, xlat_quick, win_en);
        ratio = (sel == RATE_QUICK) ? QUICK_V : BASE_V;
    end

endmodule

// File: rtl/wst_acc_counter.sv
module wst_acc_counter #(
    parameter int CNT_W = 2,
    parameter int RW    = 3,
    parameter bit PULSE_SAFE = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_stb,
    input  logic          fast_clk,
    input  logic [RW-1:0] ratio,
    output logic          stretch
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } state_t;

    state_t st_d, st_q;
    logic [RW-1:0] bump;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        bump     = RW'(st_q.cnt) + RW'(1);
        if (!fast_clk || ratio == '0) begin
            st_d.cnt = '0;
        end else if (acc_stb) begin
            if (bump >= ratio) begin
                st_d.req = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = bump[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stretch = st_q.req;

    // R1: reset leaves a clean state
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!st_q.req && st_q.cnt == '0));

    // R2: slow mode raises nothing and empties the count
    assert_slow_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(fast_clk) |-> (!st_q.req && st_q.cnt == '0));

    // R7: a request always follows a strobe
    assert_needs_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.req |-> $past(acc_stb));

    // R7: no strobe, count kept
    assert_hold_count_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(fast_clk) && !$past(acc_stb) && $past(ratio) != '0 && !$past(rst))
            |-> $stable(st_q.cnt));

    // R6: request restarts the count
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.req |-> st_q.cnt == '0);

    generate
        if (PULSE_SAFE) begin : g_pulse
            // R6: request is one cycle wide
            assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
                st_q.req |=> !st_q.req);
        end
    endgenerate

endmodule

// File: rtl/wst_stretcher.sv
module wst_stretcher #(
    parameter int RATIO_BASE  = 3,
    parameter int RATIO_QUICK = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_stb,
    input  logic fast_clk,
    input  logic xlat_en,
    input  logic xlat_quick,
    input  logic win_en,
    output logic stretch
);
    localparam int RMAX  = (RATIO_BASE > RATIO_QUICK) ? RATIO_BASE : RATIO_QUICK;
    localparam int CNT_W = (RMAX > 1) ? $clog2(RMAX) : 1;
    localparam int RW    = CNT_W + 1;
    localparam bit PULSE_SAFE = (RATIO_BASE != 1) && (RATIO_QUICK != 1);

    logic [RW-1:0] ratio;

    wst_ratio_sel #(
        .RATIO_BASE (RATIO_BASE),
        .RATIO_QUICK(RATIO_QUICK),
        .RW         (RW)
    ) u_sel (
        .xlat_en   (xlat_en),
        .xlat_quick(xlat_quick),
        .win_en    (win_en),
        .ratio     (ratio)
    );

    wst_acc_counter #(
        .CNT_W     (CNT_W),
        .RW        (RW),
        .PULSE_SAFE(PULSE_SAFE)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .acc_stb (acc_stb),
        .fast_clk(fast_clk),
        .ratio   (ratio),
        .stretch (stretch)
    );

    generate
        if (RATIO_QUICK == 0) begin : g_zero_quick
            // R8: zero ratio selected, no request
            assert_zero_quick_R8: assert property (@(posedge clk) disable iff (rst)
                $past(xlat_quick) |-> !stretch);
        end
        if (RATIO_BASE == 0) begin : g_zero_base
            // R8: zero ratio selected, no request
            assert_zero_base_R8: assert property (@(posedge clk) disable iff (rst)
                (!$past(xlat_quick) && !($past(xlat_en) && $past(win_en))) |-> !stretch);
        end
    endgenerate

endmodule

// File: tb/wst_stretcher_test.sv
module wst_stretcher_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_stb = 1'b0;
    logic fast_clk = 1'b1;
    logic xlat_en = 1'b0;
    logic xlat_quick = 1'b0;
    logic win_en = 1'b0;
    logic stretch, stretch_z;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    exp_main;
        bit    exp_zero;
        string tag;
    } item_t;

    item_t sb[$];
    int mcnt = 0;
    int zcnt = 0;

    always #5 clk = ~clk;

    wst_stretcher uut (
        .clk(clk), .rst(rst), .acc_stb(acc_stb), .fast_clk(fast_clk),
        .xlat_en(xlat_en), .xlat_quick(xlat_quick), .win_en(win_en),
        .stretch(stretch)
    );

    wst_stretcher #(.RATIO_BASE(3), .RATIO_QUICK(0)) uut_zero (
        .clk(clk), .rst(rst), .acc_stb(acc_stb), .fast_clk(fast_clk),
        .xlat_en(xlat_en), .xlat_quick(xlat_quick), .win_en(win_en),
        .stretch(stretch_z)
    );

    function automatic bit model(inout int cnt, input int ratio,
                                 input bit r, input bit s, input bit f);
        if (r || !f || ratio == 0) begin
            cnt = 0;
            return 1'b0;
        end
        if (s) begin
            if (cnt + 1 >= ratio) begin
                cnt = 0;
                return 1'b1;
            end
            cnt = cnt + 1;
        end
        return 1'b0;
    endfunction

    task automatic step(input bit r, input bit s, input bit f,
                        input bit xe, input bit xq, input bit we, input string tag);
        item_t it;
        bit quick;
        @(negedge clk);
        rst = r; acc_stb = s; fast_clk = f;
        xlat_en = xe; xlat_quick = xq; win_en = we;
        quick = xq || (xe && we);
        it.exp_main = model(mcnt, quick ? 2 : 3, r, s, f);
        it.exp_zero = model(zcnt, quick ? 0 : 3, r, s, f);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares one result per clock edge against the scoreboard
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (stretch !== it.exp_main) begin
                errors++;
                $display("FAIL %s: stretch=%0b expected %0b at %0t",
                         it.tag, stretch, it.exp_main, $time);
            end
            checks++;
            if (stretch_z !== it.exp_zero) begin
                errors++;
                $display("FAIL %s: zero-ratio stretch=%0b expected %0b at %0t",
                         it.tag, stretch_z, it.exp_zero, $time);
            end
        end
    end

    initial begin
        #200000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, a strobe during reset is not counted
        step(1, 1, 1, 0, 0, 0, "R1");
        step(1, 1, 1, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 0, "R1");
        // R3 and R6: third strobe completes, one-cycle pulse
        step(0, 1, 1, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 1, 1, 0, 0, 0, "R6");
        step(0, 1, 1, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, "R6");
        // R7: gaps keep the count
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 1, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 1, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 1, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, 0, "R7");
        // R4: fast-translation flag, ratio 2; R8 on the zero instance
        for (int i = 0; i < 7; i++) step(0, 1, 1, 0, 1, 0, "R4");
        step(0, 0, 1, 0, 1, 0, "R8");
        // R5: window alone keeps 3
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, 1, "R5");
        // R5: translation alone keeps 3
        for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 0, "R5");
        // R5: both enabled, ratio 2
        for (int i = 0; i < 6; i++) step(0, 1, 1, 1, 0, 1, "R5");
        step(0, 0, 1, 1, 0, 1, "R8");
        // R2: slow mode drops the count, collides with completing strobe
        step(0, 1, 1, 0, 0, 0, "R2");
        step(0, 1, 1, 0, 0, 0, "R2");
        step(0, 1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 0, "R2");
        // R1: reset collides with completing strobe
        step(0, 1, 1, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 0, "R1");
        step(1, 1, 1, 0, 0, 0, "R1");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 0, "R1");
        // R9: ratio cut from 3 to 2 with count at 2
        step(0, 1, 1, 0, 0, 0, "R9");
        step(0, 1, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 0, 1, 0, "R9");
        step(0, 1, 1, 0, 1, 0, "R9");
        step(0, 0, 1, 0, 1, 0, "R9");
        // R8: zero instance back in base mode counts from zero
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 0, 0, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule